// File: doc/BRIEF.md
# Clock Output Mode Controller

This block decides what each output of a grouped clock bank drives. Six groups are served: two processor clocks, eight memory clocks, six stoppable bus clocks, one free-running bus clock, three reference clocks and two fixed-rate outputs whose rate each picks between a fast and a slow source. The block is built for a single fabric clock `clk`. Every "clock" it handles arrives as a level that is sampled on that clock: the normal per-group sources, a separate test clock, and the two stop requests. The outputs are registered levels with a per-output drive-enable.

A configuration byte chooses one of four operating modes. Normal and spread modes pass the sampled group sources through. Test mode replaces every group with the test clock divided by a fixed ratio for that group. Tristate mode drops every drive-enable. The spread-type and spread-depth bits are only exported to an external modulator, and they are forced to zero outside spread mode. Per-output enable bits and two active-low stop inputs gate the outputs. Gating changes only while the source is low, so a gated output never produces a shortened high pulse.

Top module: `clkmode_ctrl`

## Requirements
- R1: In normal mode (config bits [1:0] = 00) and in spread mode (10), every output copies its group source two `clk` edges after the source is sampled, and every drive-enable is 1.
- R2: In tristate mode (bits [1:0] = 11), every `clk_oe` bit and every `clk_out` bit is 0 one edge after the mode is written.
- R3: In test mode (bits [1:0] = 01), the processor outputs (indices 0-1) and the memory outputs (indices 2-9) toggle on every rising edge of `test_clk`, which divides it by 2.
- R4: In test mode, the bus outputs (indices 10-15) and the free-running bus output (index 16) divide `test_clk` by 4, and the reference outputs (indices 17-19) carry `test_clk` undivided.
- R5: Fixed output 20 follows config bit 2 and fixed output 21 follows bit 3. A value of 1 selects `hi_src`, or `test_clk`/2 in test mode. A value of 0 selects `lo_src`, or `test_clk`/4 in test mode.
- R6: `spread_en` is 1 only in spread mode. In that mode `spread_down` equals config bit 5 and `spread_narrow` equals config bit 4, and both are 0 in every other mode.
- R7: Reset loads the config byte with 0x0C and sets every enable bit to 1. During reset all outputs and drive-enables are 0.
- R8: The test dividers are held cleared outside test mode. On entry the first rising edge of `test_clk` raises every divided output on the same `clk` edge.
- R9: A write to address 0 loads the config byte. A write to address k (1-3) loads the enable bits for outputs 8(k-1) to 8(k-1)+7 from data bits 0-7, and bits beyond output 21 are ignored. An output whose enable bit is 0 is held low while its drive-enable stays 1.
- R10: `cpu_stop_n` = 0 holds outputs 0-1 low. `pci_stop_n` = 0 holds outputs 10-15 low and leaves output 16 running.
- R11: An enable or stop change takes effect only while that output's source is low. Every high pulse on a gated output therefore has the full source high width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 config, 1-3 enables) |
| wr_data | input | 8 | Register write data |
| test_clk | input | 1 | Test clock level |
| cpu_src | input | 1 | Processor group source level |
| sdr_src | input | 1 | Memory group source level |
| pci_src | input | 1 | Bus group source level (also feeds free-running output) |
| ref_src | input | 1 | Reference group source level |
| hi_src | input | 1 | Fast fixed-rate source level |
| lo_src | input | 1 | Slow fixed-rate source level |
| cpu_stop_n | input | 1 | Active-low processor clock stop |
| pci_stop_n | input | 1 | Active-low bus clock stop |
| clk_out | output | 22 | Output levels, index layout per R3-R5 |
| clk_oe | output | 22 | Per-output drive-enable |
| spread_en | output | 1 | Spread modulation on |
| spread_down | output | 1 | Down-spread selected |
| spread_narrow | output | 1 | Narrow spread depth selected |

## Verification
The hardest case to reach is a stop or disable request that arrives while an output is in the middle of a high pulse. That case is where a truncated pulse would show. The stimulus sweeps the start and end of each stop request across every phase of the processor and bus sources, in normal and in test mode. Meanwhile the high-run length of a processor output is measured at the pins. Test mode is also re-entered at three test-clock rates so that the divider phase on entry is exercised from different states.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;

  localparam logic [7:0] CFG_RESET     = 8'h0C;
  localparam int         BIT_SS_DOWN   = 5;
  localparam int         BIT_SS_NARROW = 4;
  localparam int         BIT_FSEL0     = 2;
endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
#(
  parameter int N_OUT = 22,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       cfg_q,
  output logic [N_OUT-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else if (wr_en && wr_addr == '0) cfg_q <= wr_data;
  end

  // enable byte k+1 covers outputs 8k .. 8k+7
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < N_OUT; i++) begin
        if (wr_addr == AW'(i / 8 + 1)) en_q[i] <= wr_data[i % 8];
      end
    end
  end
endmodule

// File: rtl/clkmode_tdiv.sv
module clkmode_tdiv #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic level,
  output logic q
);
  generate
    if (RATIO <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= run & level;
      end
    end else begin : g_div
      localparam int HALF = RATIO / 2;
      localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
      logic          prev;
      logic [CW-1:0] cnt;
      logic          rise;
      assign rise = level & ~prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev <= 1'b0;
          cnt  <= '0;
          q    <= 1'b0;
        end else begin
          prev <= level;
          if (!run) begin
            cnt <= '0;
            q   <= 1'b0;
          end else if (rise) begin
            if (cnt == '0) q <= ~q;
            cnt <= (cnt == CW'(HALF - 1)) ? '0 : cnt + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/clkmode_gate.sv
module clkmode_gate (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic want,
  input  logic hiz,
  output logic gate_o,
  output logic q
);
  // enable is re-sampled only while the source sits low
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o <= 1'b1;
      q      <= 1'b0;
    end else begin
      q <= src & gate_o & ~hiz;
      if (!src) gate_o <= want;
    end
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int N_CPU   = 2,
  parameter int N_SDR   = 8,
  parameter int N_PCI   = 6,
  parameter int N_REF   = 3,
  parameter int N_FIX   = 2,
  parameter int DIV_CPU = 2,
  parameter int DIV_SDR = 2,
  parameter int DIV_PCI = 4,
  parameter int DIV_REF = 1,
  parameter int DIV_HI  = 2,
  parameter int DIV_LO  = 4,
  parameter int AW      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic test_clk,
  input  logic cpu_src,
  input  logic sdr_src,
  input  logic pci_src,
  input  logic ref_src,
  input  logic hi_src,
  input  logic lo_src,
  input  logic cpu_stop_n,
  input  logic pci_stop_n,
  output logic [N_CPU+N_SDR+N_PCI+N_REF+N_FIX:0] clk_out,
  output logic [N_CPU+N_SDR+N_PCI+N_REF+N_FIX:0] clk_oe,
  output logic spread_en,
  output logic spread_down,
  output logic spread_narrow
);
  localparam int N_OUT = N_CPU + N_SDR + N_PCI + 1 + N_REF + N_FIX;
  localparam int O_SDR = N_CPU;
  localparam int O_PCI = O_SDR + N_SDR;
  localparam int O_PCF = O_PCI + N_PCI;
  localparam int O_REF = O_PCF + 1;
  localparam int O_FIX = O_REF + N_REF;

  logic [7:0]       cfg_q;
  logic [N_OUT-1:0] en_q;
  mode_e            mode;
  logic             test_on, hiz_on;
  logic [5:0]       pll_q;   // 0 cpu, 1 sdr, 2 pci, 3 ref, 4 hi, 5 lo
  logic             d_cpu, d_sdr, d_pci, d_ref, d_hi, d_lo;
  logic [N_OUT-1:0] src_v, want_v, gate_v;

  clkmode_regs #(.N_OUT(N_OUT), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q), .en_q(en_q)
  );

  assign mode    = mode_e'(cfg_q[1:0]);
  assign test_on = (mode == MODE_TEST);
  assign hiz_on  = (mode == MODE_HIZ);

  assign spread_en     = (mode == MODE_SPREAD);
  assign spread_down   = spread_en & cfg_q[BIT_SS_DOWN];
  assign spread_narrow = spread_en & cfg_q[BIT_SS_NARROW];

  always_ff @(posedge clk) begin
    if (rst) pll_q <= '0;
    else     pll_q <= {lo_src, hi_src, ref_src, pci_src, sdr_src, cpu_src};
  end

  clkmode_tdiv #(.RATIO(DIV_CPU)) u_div_cpu (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_cpu));
  clkmode_tdiv #(.RATIO(DIV_SDR)) u_div_sdr (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_sdr));
  clkmode_tdiv #(.RATIO(DIV_PCI)) u_div_pci (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_pci));
  clkmode_tdiv #(.RATIO(DIV_REF)) u_div_ref (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_ref));
  clkmode_tdiv #(.RATIO(DIV_HI))  u_div_hi  (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_hi));
  clkmode_tdiv #(.RATIO(DIV_LO))  u_div_lo  (.clk(clk), .rst(rst), .run(test_on), .level(test_clk), .q(d_lo));

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      if (i < O_SDR) begin : g_cpu
        assign src_v[i]  = test_on ? d_cpu : pll_q[0];
        assign want_v[i] = en_q[i] & cpu_stop_n;
      end else if (i < O_PCI) begin : g_sdr
        assign src_v[i]  = test_on ? d_sdr : pll_q[1];
        assign want_v[i] = en_q[i];
      end else if (i < O_PCF) begin : g_pci
        assign src_v[i]  = test_on ? d_pci : pll_q[2];
        assign want_v[i] = en_q[i] & pci_stop_n;
      end else if (i < O_REF) begin : g_pcf
        assign src_v[i]  = test_on ? d_pci : pll_q[2];
        assign want_v[i] = en_q[i];
      end else if (i < O_FIX) begin : g_ref
        assign src_v[i]  = test_on ? d_ref : pll_q[3];
        assign want_v[i] = en_q[i];
      end else begin : g_fix
        logic sel;
        assign sel       = cfg_q[BIT_FSEL0 + i - O_FIX];
        assign src_v[i]  = test_on ? (sel ? d_hi : d_lo) : (sel ? pll_q[4] : pll_q[5]);
        assign want_v[i] = en_q[i];
      end

      clkmode_gate u_gate (
        .clk(clk), .rst(rst), .src(src_v[i]), .want(want_v[i]),
        .hiz(hiz_on), .gate_o(gate_v[i]), .q(clk_out[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_oe <= '0;
    else     clk_oe <= {N_OUT{~hiz_on}};
  end
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk #(
  parameter int N_OUT = 22
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [N_OUT-1:0] gate,
  input logic [N_OUT-1:0] out,
  input logic [N_OUT-1:0] oe,
  input logic             ss_en,
  input logic             ss_down,
  input logic             ss_narrow,
  input logic             div2,
  input logic             div4
);
  p_drive_r1: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b11) |=> (oe == '1));

  p_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (oe == '0 && out == '0));

  p_spread_r6: assert property (@(posedge clk) disable iff (rst)
    (ss_down || ss_narrow) |-> ss_en);

  p_align_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(div4) |-> $rose(div2));

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    p_held_low_r9: assert property (@(posedge clk) disable iff (rst)
      !gate[i] |=> !out[i]);
    p_low_phase_r11: assert property (@(posedge clk) disable iff (rst)
      $fell(gate[i]) |-> !out[i]);
  end
endmodule

bind clkmode_ctrl clkmode_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .mode(cfg_q[1:0]), .gate(gate_v), .out(clk_out),
  .oe(clk_oe), .ss_en(spread_en), .ss_down(spread_down),
  .ss_narrow(spread_narrow), .div2(d_cpu), .div4(d_pci)
);

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
  localparam int N_OUT = 22;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic test_clk = 1'b0;
  logic cpu_src = 0, sdr_src = 0, pci_src = 0, ref_src = 0, hi_src = 0, lo_src = 0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic [N_OUT-1:0] clk_out, clk_oe;
  logic spread_en, spread_down, spread_narrow;

  clkmode_ctrl u_clkmode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .test_clk(test_clk), .cpu_src(cpu_src), .sdr_src(sdr_src), .pci_src(pci_src),
    .ref_src(ref_src), .hi_src(hi_src), .lo_src(lo_src),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .clk_out(clk_out), .clk_oe(clk_oe), .spread_en(spread_en),
    .spread_down(spread_down), .spread_narrow(spread_narrow)
  );

  int compared = 0, mismatched = 0;
  string req = "R7";
  bit live = 0;

  // ---------------- stimulus sources ----------------
  int cyc = 0, tcnt = 0, thalf = 2;
  always @(negedge clk) begin
    cyc++;
    cpu_src = (cyc % 4) < 2;
    sdr_src = ((cyc + 1) % 4) < 2;
    pci_src = (cyc % 8) < 4;
    ref_src = (cyc % 6) < 3;
    hi_src  = ((cyc + 2) % 6) < 3;
    lo_src  = (cyc % 12) < 6;
    tcnt++;
    if (tcnt >= thalf) begin
      test_clk = ~test_clk;
      tcnt = 0;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_cfg;
  logic [N_OUT-1:0] m_en, m_gate, m_out, m_oe;
  bit m_p_cpu, m_p_sdr, m_p_pci, m_p_ref, m_p_hi, m_p_lo, m_tprev, m_tlev;
  int m_edges;

  function automatic bit dv(int e, int half);
    return (e >= 1) && (((e - 1) / half) % 2 == 0);
  endfunction

  always @(posedge clk) begin : model
    logic [N_OUT-1:0] s, w;
    bit tst, hz, sel;
    if (rst) begin
      m_cfg = 8'h0C; m_en = '1; m_gate = '1; m_out = '0; m_oe = '0;
      {m_p_cpu, m_p_sdr, m_p_pci, m_p_ref, m_p_hi, m_p_lo} = '0;
      m_tprev = 0; m_tlev = 0; m_edges = 0;
    end else begin
      tst = (m_cfg[1:0] == 2'b01);
      hz  = (m_cfg[1:0] == 2'b11);
      for (int i = 0; i < N_OUT; i++) begin
        if (i < 2)       begin s[i] = tst ? dv(m_edges, 1) : m_p_cpu; w[i] = m_en[i] & cpu_stop_n; end
        else if (i < 10) begin s[i] = tst ? dv(m_edges, 1) : m_p_sdr; w[i] = m_en[i]; end
        else if (i < 16) begin s[i] = tst ? dv(m_edges, 2) : m_p_pci; w[i] = m_en[i] & pci_stop_n; end
        else if (i < 17) begin s[i] = tst ? dv(m_edges, 2) : m_p_pci; w[i] = m_en[i]; end
        else if (i < 20) begin s[i] = tst ? m_tlev : m_p_ref; w[i] = m_en[i]; end
        else begin
          sel = m_cfg[2 + i - 20];
          s[i] = tst ? (sel ? dv(m_edges, 1) : dv(m_edges, 2)) : (sel ? m_p_hi : m_p_lo);
          w[i] = m_en[i];
        end
      end
      m_out = s & m_gate & {N_OUT{~hz}};
      m_oe  = {N_OUT{~hz}};
      for (int i = 0; i < N_OUT; i++) if (!s[i]) m_gate[i] = w[i];
      {m_p_cpu, m_p_sdr, m_p_pci, m_p_ref, m_p_hi, m_p_lo} =
        {cpu_src, sdr_src, pci_src, ref_src, hi_src, lo_src};
      if (!tst) m_edges = 0;
      else if (test_clk && !m_tprev) m_edges++;
      m_tprev = test_clk;
      m_tlev  = tst & test_clk;
      if (wr_en) begin
        if (wr_addr == 0) m_cfg = wr_data;
        else for (int i = 0; i < N_OUT; i++) if (i / 8 + 1 == wr_addr) m_en[i] = wr_data[i % 8];
      end
    end
    live = 1;
  end

  function automatic logic [2:0] exp_ss();
    bit on;
    on = (m_cfg[1:0] == 2'b10);
    return {on, on & m_cfg[5], on & m_cfg[4]};
  endfunction

  always @(negedge clk) begin
    if (live) begin
      compared++;
      if (clk_out !== m_out || clk_oe !== m_oe || {spread_en, spread_down, spread_narrow} !== exp_ss()) begin
        mismatched++;
        $display("FAIL %s cyc %0d: out=%h oe=%h ss=%b expected out=%h oe=%h ss=%b", req, cyc,
                 clk_out, clk_oe, {spread_en, spread_down, spread_narrow}, m_out, m_oe, exp_ss());
      end
    end
  end

  // ---------------- high-pulse width monitor (R11) ----------------
  bit pw_on = 0;
  int hrun = 0;
  always @(negedge clk) begin
    if (clk_out[0] === 1'b1) hrun++;
    else begin
      if (pw_on && hrun > 0) begin
        compared++;
        if (hrun != 2) begin
          mismatched++;
          $display("FAIL R11: cpu high pulse %0d cycles, expected 2", hrun);
        end
      end
      hrun = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic count_rises(int n, int idx, output int r);
    logic prev;
    r = 0;
    prev = clk_out[idx];
    repeat (n) begin
      @(negedge clk);
      if (clk_out[idx] && !prev) r++;
      prev = clk_out[idx];
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  int rc, rp, rr, rf;
  initial begin
    repeat (4) @(negedge clk);
    chk("R7 reset out", 32'(clk_out), 32'd0);
    chk("R7 reset oe", 32'(clk_oe), 32'd0);
    rst = 0;
    req = "R1";
    repeat (40) @(negedge clk);
    chk("R1 drive on", 32'(clk_oe), 32'h3FFFFF);
    chk("R7 spread off after reset", {29'd0, spread_en, spread_down, spread_narrow}, 32'd0);

    req = "R5"; wr(0, 8'h00); repeat (30) @(negedge clk);
    wr(0, 8'h04); repeat (30) @(negedge clk);

    req = "R6"; wr(0, 8'h32);
    chk("R6 spread on", {29'd0, spread_en, spread_down, spread_narrow}, 32'd7);
    repeat (10) @(negedge clk);
    wr(0, 8'h31);
    chk("R6 spread bits blocked in test", {29'd0, spread_en, spread_down, spread_narrow}, 32'd0);
    wr(0, 8'h22); repeat (20) @(negedge clk);
    chk("R6 down only", {29'd0, spread_en, spread_down, spread_narrow}, 32'd6);

    req = "R3"; wr(0, 8'h0C); repeat (4) @(negedge clk);
    thalf = 2; wr(0, 8'h0D); repeat (10) @(negedge clk);
    fork
      count_rises(64, 0, rc);
      count_rises(64, 10, rp);
      count_rises(64, 17, rr);
      count_rises(64, 21, rf);
    join
    chk("R3 cpu rises", 32'(rc), 32'd8);
    chk("R4 pci rises", 32'(rp), 32'd4);
    chk("R4 ref rises", 32'(rr), 32'd16);
    chk("R5 fixed hi in test", 32'(rf), 32'd8);

    req = "R8";
    wr(0, 8'h0C); repeat (5) @(negedge clk);
    thalf = 1; wr(0, 8'h0D); repeat (40) @(negedge clk);
    wr(0, 8'h0C); repeat (3) @(negedge clk);
    thalf = 3; wr(0, 8'h01); repeat (50) @(negedge clk);

    req = "R10";
    for (int k = 0; k < 8; k++) begin
      cpu_stop_n = 0; repeat (3 + k) @(negedge clk);
      cpu_stop_n = 1; pci_stop_n = 0; repeat (5 + k) @(negedge clk);
      pci_stop_n = 1; repeat (2) @(negedge clk);
    end
    wr(0, 8'h0C); repeat (4) @(negedge clk);
    cpu_stop_n = 0; pci_stop_n = 0; repeat (4) @(negedge clk);
    fork
      count_rises(32, 1, rc);
      count_rises(32, 15, rp);
      count_rises(32, 16, rf);
    join
    chk("R10 cpu halted", 32'(rc), 32'd0);
    chk("R10 pci halted", 32'(rp), 32'd0);
    chk("R10 free-running pci runs", 32'(rf), 32'd4);
    cpu_stop_n = 1; pci_stop_n = 1; repeat (8) @(negedge clk);

    req = "R11"; pw_on = 1;
    for (int k = 0; k < 12; k++) begin
      cpu_stop_n = 0; repeat (1 + k % 5) @(negedge clk);
      cpu_stop_n = 1; repeat (2 + k % 3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    pw_on = 0;

    req = "R9";
    wr(1, 8'hFC); wr(3, 8'hFE); repeat (4) @(negedge clk);
    fork
      count_rises(32, 0, rc);
      count_rises(32, 16, rf);
    join
    chk("R9 disabled stays low", 32'(rc), 32'd0);
    chk("R9 disabled pcif low", 32'(rf), 32'd0);
    chk("R9 drive kept", 32'(clk_oe[0]), 32'd1);
    wr(1, 8'hFF); wr(3, 8'hFF); repeat (10) @(negedge clk);

    req = "R2"; wr(0, 8'h0F); repeat (10) @(negedge clk);
    chk("R2 oe low", 32'(clk_oe), 32'd0);
    chk("R2 out low", 32'(clk_out), 32'd0);
    wr(0, 8'h0C); repeat (10) @(negedge clk);
    summary();
  end
endmodule